// File: doc/BRIEF.md
# Self-ID Reception Status Tracker

This block keeps a single 32-bit, read-only status word that describes the self-identification phase that follows every serial-bus reset. Three event strobes drive it. A bus-reset pulse starts a new self-ID phase. A quadlet-stored strobe fires once for every self-ID quadlet written to host memory. A store-error strobe reports that a write to host memory failed.

The status word holds three fields. An 8-bit generation counter counts detected bus resets. An 11-bit size field counts the stored quadlets of the current phase. A sticky error flag records a failed store. Software reads the word and cannot write it. Every field changes only through the event strobes or through the chip reset.

The chip reset is asynchronous and active low. Its release is synchronised to the clock inside the block. All fields are registered, so the status word shows the effect of a strobe one clock edge after the strobe is sampled.

Top module: `sid_status_tracker`

## Requirements
- R1: While the chip reset is asserted, and after its synchronised release, the status word reads all zeros.
- R2: Bits 23:16 hold the generation count. It increases by one on each cycle in which the bus-reset input is high, and it wraps from 255 to 0.
- R3: Bits 12:2 hold the size in quadlets. It increases by one on each cycle in which the quadlet strobe is high and the bus-reset input is low.
- R4: The size field saturates at 2047. A quadlet strobe at 2047 leaves it unchanged.
- R5: A bus reset sets the size field to zero. When a quadlet strobe arrives in the same cycle, the bus reset takes precedence: the size becomes zero and the generation still increments.
- R6: Bit 31 is the error flag. A store-error strobe without a bus reset sets it to 1, and it stays at 1 through any number of idle or quadlet cycles.
- R7: A bus reset clears the error flag. When a store-error strobe arrives in the same cycle, the bus reset takes precedence and the flag becomes 0.
- R8: Bits 30:24, 15:13 and 1:0 always read as zero.
- R9: The status word changes at the clock edge that samples a strobe, and it holds its value in cycles with no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| bus_rst_i | input | 1 | Pulse for each detected serial-bus reset |
| quad_stored_i | input | 1 | Pulse for each self-ID quadlet stored to host memory |
| store_err_i | input | 1 | Pulse when a self-ID store to host memory fails |
| status_o | output | 32 | Status word: error flag, generation, size |

## Verification
The hardest states to reach from the ports are the two ends of the counters: a size field held at 2047 while more quadlets arrive, and a generation count that wraps past 255. The stimulus reaches them with long directed runs of single strobes. It checks the value just before each boundary and again just after it. The precedence cases need two strobes in the same cycle, so the vector table places the bus reset together with a quadlet strobe, an error strobe, or both.

// File: rtl/sid_status_pkg.sv
package sid_status_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned GEN_W    = 8;
  localparam int unsigned SIZE_W   = 11;
  localparam int unsigned ERR_BIT  = 31;
  localparam int unsigned GEN_LSB  = 16;
  localparam int unsigned SIZE_LSB = 2;

  // Word layout flags carried with each event sample
  typedef struct packed {
    logic bus_rst;
    logic quad;
    logic err;
  } sid_evt_t;
endpackage

// File: rtl/sid_rst_sync.sv
module sid_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sid_gen_ctr.sv
module sid_gen_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = step;
    cnt_d  = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/sid_size_ctr.sv
module sid_size_ctr #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         at_max;

  always_comb begin
    at_max = (cnt_q == MAX_VAL);
    cnt_en = clr | (inc & ~at_max);
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/sid_err_flag.sv
module sid_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = clr | set;
    flag_d  = ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/sid_status_tracker.sv
module sid_status_tracker
  import sid_status_pkg::*;
#(
  parameter int unsigned G_W        = GEN_W,
  parameter int unsigned S_W        = SIZE_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_i,
  input  logic              quad_stored_i,
  input  logic              store_err_i,
  output logic [WORD_W-1:0] status_o
);
  logic           rst_sync_n;
  logic [G_W-1:0] gen;
  logic [S_W-1:0] size;
  logic           err;
  sid_evt_t       evt;

  always_comb begin
    evt.bus_rst = bus_rst_i;
    evt.quad    = quad_stored_i;
    evt.err     = store_err_i;
  end

  sid_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  sid_gen_ctr #(.W(G_W)) u_gen (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (evt.bus_rst),
    .count (gen)
  );

  sid_size_ctr #(.W(S_W)) u_size (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (evt.bus_rst),
    .inc   (evt.quad),
    .count (size)
  );

  sid_err_flag u_err (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (evt.bus_rst),
    .set   (evt.err),
    .flag  (err)
  );

  always_comb begin
    status_o                     = '0;
    status_o[ERR_BIT]            = err;
    status_o[GEN_LSB +: G_W]     = gen;
    status_o[SIZE_LSB +: S_W]    = size;
  end
endmodule

module sid_status_checker
  import sid_status_pkg::*;
(
  input logic              clk,
  input logic              rst_ok_n,
  input logic              bus_rst_i,
  input logic              quad_stored_i,
  input logic              store_err_i,
  input logic [WORD_W-1:0] status_o
);
  logic [7:0]  gen_v;
  logic [10:0] size_v;
  logic        err_v;
  assign gen_v  = status_o[23:16];
  assign size_v = status_o[12:2];
  assign err_v  = status_o[31];

  p_gen_step_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    bus_rst_i |=> gen_v == 8'($past(gen_v) + 8'd1));

  p_size_step_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!bus_rst_i && quad_stored_i && size_v != 11'h7FF) |=> size_v == 11'($past(size_v) + 11'd1));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!bus_rst_i && size_v == 11'h7FF) |=> size_v == 11'h7FF);

  p_size_clear_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    bus_rst_i |=> size_v == 11'd0);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!bus_rst_i && (err_v || store_err_i)) |=> err_v);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    bus_rst_i |=> !err_v);

  p_zero_bits_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (status_o & 32'h7F00_E003) == 32'd0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!bus_rst_i && !quad_stored_i && !store_err_i) |=> $stable(status_o));
endmodule

bind sid_status_tracker sid_status_checker u_sid_status_checker (
  .clk           (clk),
  .rst_ok_n      (rst_sync_n),
  .bus_rst_i     (bus_rst_i),
  .quad_stored_i (quad_stored_i),
  .store_err_i   (store_err_i),
  .status_o      (status_o)
);

// File: tb/sid_status_tracker_bench.sv
module sid_status_tracker_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_rst_i;
  logic        quad_stored_i;
  logic        store_err_i;
  logic [31:0] status_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  sid_status_tracker u_sid_status_tracker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rst_i     (bus_rst_i),
    .quad_stored_i (quad_stored_i),
    .store_err_i   (store_err_i),
    .status_o      (status_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: {bus, quad, err, exp_gen[7:0], exp_size[10:0], exp_err}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {3'b010, 8'd0, 11'd1, 1'b0},
    {3'b010, 8'd0, 11'd2, 1'b0},
    {3'b011, 8'd0, 11'd3, 1'b1},
    {3'b000, 8'd0, 11'd3, 1'b1},
    {3'b100, 8'd1, 11'd0, 1'b0},
    {3'b110, 8'd2, 11'd0, 1'b0},
    {3'b010, 8'd2, 11'd1, 1'b0},
    {3'b101, 8'd3, 11'd0, 1'b0},
    {3'b001, 8'd3, 11'd0, 1'b1},
    {3'b011, 8'd3, 11'd1, 1'b1},
    {3'b111, 8'd4, 11'd0, 1'b0},
    {3'b010, 8'd4, 11'd1, 1'b0}
  };

  function automatic logic [31:0] word(input logic [7:0] g, input logic [10:0] s, input logic e);
    logic [31:0] w;
    w = '0;
    w[31] = e;
    w[23:16] = g;
    w[12:2] = s;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic q, input logic e);
    @(negedge clk);
    bus_rst_i = b; quad_stored_i = q; store_err_i = e;
    @(posedge clk);
    #1;
    bus_rst_i = 1'b0; quad_stored_i = 1'b0; store_err_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_rst_i = 1'b0; quad_stored_i = 1'b0; store_err_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 during reset", status_o, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 after release", status_o, 32'd0);

    // Vector table: R2 R3 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][22], VEC[i][21], VEC[i][20]);
      chk($sformatf("R2/R3/R5/R6/R7/R8 vector %0d", i), status_o,
          word(VEC[i][19:12], VEC[i][11:1], VEC[i][0]));
    end

    // R9: idle cycles hold value
    step(1'b0, 1'b0, 1'b1);
    repeat (20) step(1'b0, 1'b0, 1'b0);
    chk("R9 hold / R6 sticky", status_o, word(8'd4, 11'd1, 1'b1));
    repeat (5) step(1'b0, 1'b1, 1'b0);
    chk("R6 sticky across quadlets", status_o, word(8'd4, 11'd6, 1'b1));

    // R4 saturation
    step(1'b1, 1'b0, 1'b0);
    chk("R5 clear before saturation run", status_o, word(8'd5, 11'd0, 1'b0));
    repeat (2046) step(1'b0, 1'b1, 1'b0);
    chk("R3 size 2046", status_o, word(8'd5, 11'd2046, 1'b0));
    step(1'b0, 1'b1, 1'b0);
    chk("R4 size reaches 2047", status_o, word(8'd5, 11'd2047, 1'b0));
    repeat (3) step(1'b0, 1'b1, 1'b0);
    chk("R4 size saturated", status_o, word(8'd5, 11'd2047, 1'b0));
    step(1'b1, 1'b1, 1'b0);
    chk("R5 reset wins at saturation", status_o, word(8'd6, 11'd0, 1'b0));

    // R2 wrap
    repeat (249) step(1'b1, 1'b0, 1'b0);
    chk("R2 gen 255", status_o, word(8'd255, 11'd0, 1'b0));
    step(1'b1, 1'b0, 1'b0);
    chk("R2 gen wraps to 0", status_o, word(8'd0, 11'd0, 1'b0));
    step(1'b1, 1'b0, 1'b1);
    chk("R7 reset beats error strobe", status_o, word(8'd1, 11'd0, 1'b0));

    // R1 chip reset mid-state
    step(1'b0, 1'b1, 1'b1);
    chk("R6 set before chip reset", status_o, word(8'd1, 11'd1, 1'b1));
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1 asynchronous clear", status_o, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 zero after second release", status_o, 32'd0);

    finish_run();
  end
endmodule